// File: doc/BRIEF.md
# Streaming Vector Execution Unit

This unit carries out one vector instruction at a time over a stream of signed element pairs. A start pulse, taken only while the unit is idle, captures a 4-bit opcode and a scalar operand. Once the unit is busy it accepts one element pair per clock whenever the input valid flag is high. An element that carries the last flag ends the instruction.

Elementwise instructions produce one registered result for every accepted pair. The result carries matching valid and last flags on the output stream. Reduction instructions fold the A operands into an accumulator and present a single scalar result with a one-cycle done pulse.

The operand width is a parameter. All arithmetic wraps modulo two to the power of the width. A new instruction may start in the very cycle after the final result of the previous one appears.

Top module: `vec_exec_unit`

## Requirements
- R1: After reset, busy_o, out_valid_o, out_last_o and red_done_o are 0, and out_data_o and red_data_o are 0.
- R2: A start pulse seen while busy_o is 0 captures opcode_i and scalar_i and raises busy_o on the next clock. Element inputs presented while busy_o is 0, including in the start cycle, are ignored and produce no output.
- R3: For an elementwise opcode, each accepted element gives out_valid_o high with its result exactly one clock later. out_last_o equals that element's in_last_i, and cycles without an accepted element give out_valid_o low.
- R4: Opcode 0 yields the bitwise complement of A. Opcode 3 yields A+B. Opcode 4 yields the low W bits of A*B. Opcode 5 yields the bitwise AND of A and B.
- R5: Opcode 6 yields the signed maximum of A and B. Opcode 7 yields 1 when A is greater than or equal to B as signed values, and 0 otherwise.
- R6: Opcode 8 yields S+A, where S is the scalar captured at start; changes on scalar_i during the instruction have no effect.
- R7: Opcode 1 sums all A values of the instruction modulo 2^W. The result appears on red_data_o with red_done_o high for exactly one clock, on the clock after the last element is accepted. red_data_o then holds until the next reduction completes.
- R8: Opcode 2 yields the largest A value of the instruction as a signed number, including when every value is negative or when there is a single element.
- R9: A start pulse while busy_o is 1 is ignored, including in the cycle of the last element, and the running instruction's results are unaffected.
- R10: busy_o falls on the same clock edge that presents the final elementwise result or the reduction done pulse. A start pulse in the next cycle is accepted.
- R11: Reduction opcodes never raise out_valid_o. Unassigned opcodes 9 to 15 behave as elementwise instructions with result 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Begin an instruction (taken only when idle) |
| opcode_i | input | 4 | Instruction selector, captured at start |
| scalar_i | input | W | Scalar operand, captured at start |
| in_valid_i | input | 1 | Element pair present |
| in_last_i | input | 1 | Element pair is the final one |
| a_i | input | W | Element A(I) |
| b_i | input | W | Element B(I) |
| out_valid_o | output | 1 | Elementwise result present |
| out_last_o | output | 1 | Elementwise result is the final one |
| out_data_o | output | W | Elementwise result |
| red_done_o | output | 1 | One-cycle pulse marking a reduction result |
| red_data_o | output | W | Reduction result |
| busy_o | output | 1 | Instruction in progress |

## Verification
The hardest situations to reach from the ports are the races at instruction boundaries. One is a start pulse arriving together with the last element. Another is a new start in the very cycle busy_o drops, right while the previous done pulse is showing. The stimulus chains instructions back to back with no idle cycle between them. It also injects stray start pulses with a different opcode and scalar on random elements, the last one included, together with random idle gaps and random opcodes over all sixteen codes. Directed vectors add signed corner cases: wrapping sums, all-negative maxima, single-element reductions and equal operands for the compare.

// File: rtl/vxu_pkg.sv
package vxu_pkg;

    typedef enum logic [3:0] {
        OP_CPL  = 4'd0,
        OP_SUM  = 4'd1,
        OP_MAX  = 4'd2,
        OP_ADD  = 4'd3,
        OP_MUL  = 4'd4,
        OP_AND  = 4'd5,
        OP_LRG  = 4'd6,
        OP_TST  = 4'd7,
        OP_SADD = 4'd8
    } vop_e;

    localparam int OP_W = 4;

    function automatic logic is_reduce(input logic [OP_W-1:0] op);
        return (op == OP_SUM) || (op == OP_MAX);
    endfunction

endpackage

// File: rtl/vxu_smax.sv
module vxu_smax #(
    parameter int W = 16
) (
    input  logic [W-1:0] x_i,
    input  logic [W-1:0] y_i,
    output logic         x_ge_o,
    output logic [W-1:0] max_o
);
    always_comb begin
        x_ge_o = ($signed(x_i) >= $signed(y_i));
        max_o  = x_ge_o ? x_i : y_i;
    end
endmodule

// File: rtl/vxu_elem_alu.sv
module vxu_elem_alu
    import vxu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    input  logic [W-1:0]    s_i,
    output logic [W-1:0]    res_o
);
    localparam int PW = 2 * W;

    logic          ge;
    logic [W-1:0]  mx;
    logic [PW-1:0] prod;

    vxu_smax #(.W(W)) u_max (
        .x_i    (a_i),
        .y_i    (b_i),
        .x_ge_o (ge),
        .max_o  (mx)
    );

    always_comb begin
        prod  = {{W{1'b0}}, a_i} * {{W{1'b0}}, b_i};
        res_o = '0;
        case (op_i)
            OP_CPL:  res_o = ~a_i;
            OP_ADD:  res_o = a_i + b_i;
            OP_MUL:  res_o = prod[W-1:0];
            OP_AND:  res_o = a_i & b_i;
            OP_LRG:  res_o = mx;
            OP_TST:  res_o = {{(W-1){1'b0}}, ge};
            OP_SADD: res_o = s_i + a_i;
            default: res_o = '0;
        endcase
    end
endmodule

// File: rtl/vxu_reduce_step.sv
module vxu_reduce_step
    import vxu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic [OP_W-1:0] op_i,
    input  logic [W-1:0]    acc_i,
    input  logic [W-1:0]    a_i,
    output logic [W-1:0]    acc_o,
    output logic [W-1:0]    seed_o
);
    localparam logic [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};

    logic         ge_unused;
    logic [W-1:0] mx;

    vxu_smax #(.W(W)) u_max (
        .x_i    (acc_i),
        .y_i    (a_i),
        .x_ge_o (ge_unused),
        .max_o  (mx)
    );

    always_comb begin
        acc_o  = acc_i;
        seed_o = '0;
        case (op_i)
            OP_SUM: acc_o = acc_i + a_i;
            OP_MAX: begin
                acc_o  = mx;
                seed_o = MOST_NEG;
            end
            default: acc_o = acc_i;
        endcase
    end
endmodule

// File: rtl/vec_exec_unit.sv
module vec_exec_unit
    import vxu_pkg::*;
#(
    parameter int W = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [3:0]      opcode_i,
    input  logic [W-1:0]    scalar_i,
    input  logic            in_valid_i,
    input  logic            in_last_i,
    input  logic [W-1:0]    a_i,
    input  logic [W-1:0]    b_i,
    output logic            out_valid_o,
    output logic            out_last_o,
    output logic [W-1:0]    out_data_o,
    output logic            red_done_o,
    output logic [W-1:0]    red_data_o,
    output logic            busy_o
);
    typedef struct packed {
        logic            busy;
        logic [OP_W-1:0] op;
        logic [W-1:0]    scal;
        logic [W-1:0]    acc;
        logic            ovld;
        logic            olast;
        logic [W-1:0]    odata;
        logic            rdone;
        logic [W-1:0]    rdata;
    } state_t;

    state_t st_q, st_d;

    logic [W-1:0] alu_res;
    logic [W-1:0] acc_step;
    logic [W-1:0] acc_seed_unused;
    logic [W-1:0] new_seed;
    logic [W-1:0] seed_acc_unused;
    logic         accept;

    vxu_elem_alu #(.W(W)) u_alu (
        .op_i  (st_q.op),
        .a_i   (a_i),
        .b_i   (b_i),
        .s_i   (st_q.scal),
        .res_o (alu_res)
    );

    // running instruction's accumulator step
    vxu_reduce_step #(.W(W)) u_red (
        .op_i   (st_q.op),
        .acc_i  (st_q.acc),
        .a_i    (a_i),
        .acc_o  (acc_step),
        .seed_o (acc_seed_unused)
    );

    // seed for an instruction being started this cycle
    vxu_reduce_step #(.W(W)) u_seed (
        .op_i   (opcode_i),
        .acc_i  ('0),
        .a_i    ('0),
        .acc_o  (seed_acc_unused),
        .seed_o (new_seed)
    );

    always_comb begin
        st_d       = st_q;
        st_d.ovld  = 1'b0;
        st_d.olast = 1'b0;
        st_d.rdone = 1'b0;
        accept     = st_q.busy && in_valid_i;

        if (!st_q.busy && start_i) begin
            st_d.busy = 1'b1;
            st_d.op   = opcode_i;
            st_d.scal = scalar_i;
            st_d.acc  = new_seed;
        end

        if (accept) begin
            if (is_reduce(st_q.op)) begin
                st_d.acc = acc_step;
                if (in_last_i) begin
                    st_d.rdone = 1'b1;
                    st_d.rdata = acc_step;
                end
            end else begin
                st_d.ovld  = 1'b1;
                st_d.olast = in_last_i;
                st_d.odata = alu_res;
            end
            if (in_last_i) begin
                st_d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o      = st_q.busy;
    assign out_valid_o = st_q.ovld;
    assign out_last_o  = st_q.olast;
    assign out_data_o  = st_q.odata;
    assign red_done_o  = st_q.rdone;
    assign red_data_o  = st_q.rdata;

endmodule

// File: rtl/vec_exec_unit_chk.sv
module vec_exec_unit_chk #(
    parameter int W = 16
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start_i,
    input logic         in_valid_i,
    input logic         in_last_i,
    input logic         busy_o,
    input logic         out_valid_o,
    input logic         out_last_o,
    input logic         red_done_o,
    input logic [W-1:0] red_data_o
);
    AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o); // R2

    AST_NO_OUT_WITHOUT_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy_o && in_valid_i) |=> (!out_valid_o && !red_done_o)); // R3

    AST_LAST_REACHES_OUTPUT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && in_valid_i && in_last_i) |=> (out_last_o || red_done_o)); // R3

    AST_DONE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        red_done_o |=> !red_done_o); // R7

    AST_RED_DATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !red_done_o |-> $stable(red_data_o)); // R7

    AST_BUSY_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !(in_valid_i && in_last_i)) |=> busy_o); // R9

    AST_BUSY_DROPS_ON_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && in_valid_i && in_last_i) |=> !busy_o); // R10

    AST_STREAMS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid_o && red_done_o)); // R11
endmodule

bind vec_exec_unit vec_exec_unit_chk #(.W(W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .in_valid_i  (in_valid_i),
    .in_last_i   (in_last_i),
    .busy_o      (busy_o),
    .out_valid_o (out_valid_o),
    .out_last_o  (out_last_o),
    .red_done_o  (red_done_o),
    .red_data_o  (red_data_o)
);

// File: tb/vec_exec_unit_tb_top.sv
module vec_exec_unit_tb_top;
    localparam int W = 16;
    localparam int MAXN = 64;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start_i = 1'b0;
    logic [3:0]   opcode_i = '0;
    logic [W-1:0] scalar_i = '0;
    logic         in_valid_i = 1'b0;
    logic         in_last_i = 1'b0;
    logic [W-1:0] a_i = '0;
    logic [W-1:0] b_i = '0;
    logic         out_valid_o, out_last_o, red_done_o, busy_o;
    logic [W-1:0] out_data_o, red_data_o;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;

    logic [W-1:0] a_arr [MAXN];
    logic [W-1:0] b_arr [MAXN];

    always #10 clk = ~clk;

    vec_exec_unit #(.W(W)) dut_i (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .opcode_i(opcode_i),
        .scalar_i(scalar_i), .in_valid_i(in_valid_i), .in_last_i(in_last_i),
        .a_i(a_i), .b_i(b_i), .out_valid_o(out_valid_o), .out_last_o(out_last_o),
        .out_data_o(out_data_o), .red_done_o(red_done_o), .red_data_o(red_data_o),
        .busy_o(busy_o)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles, expected fewer", cycles);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [W-1:0] exp_elem(input logic [3:0] op, input logic [W-1:0] a,
                                              input logic [W-1:0] b, input logic [W-1:0] s);
        logic [W-1:0] p;
        p = a * b;
        case (op)
            4'd0: return ~a;
            4'd3: return a + b;
            4'd4: return p;
            4'd5: return a & b;
            4'd6: return ($signed(a) > $signed(b)) ? a : b;
            4'd7: return ($signed(a) < $signed(b)) ? '0 : {{(W-1){1'b0}}, 1'b1};
            4'd8: return s + a;
            default: return '0;
        endcase
    endfunction

    function automatic bit exp_is_red(input logic [3:0] op);
        return (op == 4'd1) || (op == 4'd2);
    endfunction

    // Entered and left at a negative edge; chains back to back (R10).
    task automatic run_instr(input logic [3:0] op, input logic [W-1:0] s, input int n,
                             input bit gaps, input bit noise);
        logic [W-1:0] acc;
        acc = (op == 4'd2) ? {1'b1, {(W-1){1'b0}}} : '0;
        start_i = 1'b1; opcode_i = op; scalar_i = s; in_valid_i = 1'b1; in_last_i = 1'b1;
        a_i = $urandom; b_i = $urandom;
        @(negedge clk);
        start_i = 1'b0; in_valid_i = 1'b0;
        chk(busy_o === 1'b1, "R2 busy after start", busy_o, 1);
        chk(red_done_o === 1'b0 && out_valid_o === 1'b0, "R2/R7 no output after start cycle",
            {red_done_o, out_valid_o}, 0);
        for (int i = 0; i < n; i++) begin
            bit inj;
            if (gaps && ($urandom % 3 == 0)) begin
                in_valid_i = 1'b0; in_last_i = 1'b1;
                @(negedge clk);
                chk(out_valid_o === 1'b0 && red_done_o === 1'b0, "R3 gap yields nothing",
                    out_valid_o, 0);
                chk(busy_o === 1'b1, "R9 busy across gap", busy_o, 1);
            end
            inj = noise && ($urandom % 4 == 0);
            in_valid_i = 1'b1; in_last_i = (i == n - 1);
            a_i = a_arr[i]; b_i = b_arr[i];
            start_i = inj;
            if (noise) begin
                opcode_i = $urandom; scalar_i = $urandom; // R6 / R9 stray values
            end
            if (op == 4'd1) acc = acc + a_arr[i];
            if (op == 4'd2 && $signed(a_arr[i]) > $signed(acc)) acc = a_arr[i];
            @(negedge clk);
            start_i = 1'b0;
            if (exp_is_red(op)) begin
                chk(out_valid_o === 1'b0, "R11 reduction gives no stream output", out_valid_o, 0);
            end else begin
                logic [W-1:0] e;
                e = exp_elem(op, a_arr[i], b_arr[i], s);
                chk(out_valid_o === 1'b1, "R3 result valid one clock later", out_valid_o, 1);
                chk(out_data_o === e, (op >= 4'd9) ? "R11 unassigned op zero" :
                    (op == 4'd8) ? "R6 scalar add" : (op == 4'd6 || op == 4'd7) ? "R5 compare ops" :
                    "R4 arithmetic/logic op", out_data_o, e);
                chk(out_last_o === (i == n - 1), "R3 last flag delayed", out_last_o, (i == n - 1));
            end
            if (i == n - 1) begin
                chk(busy_o === 1'b0, "R10/R9 busy falls with final result", busy_o, 0);
                if (exp_is_red(op)) begin
                    chk(red_done_o === 1'b1, "R7 done pulse after last", red_done_o, 1);
                    chk(red_data_o === acc, (op == 4'd1) ? "R7 sum" : "R8 max", red_data_o, acc);
                end else begin
                    chk(red_done_o === 1'b0, "R11 no done for elementwise", red_done_o, 0);
                end
            end else begin
                chk(busy_o === 1'b1, "R9 busy held mid instruction", busy_o, 1);
                chk(red_done_o === 1'b0, "R7 no done before last", red_done_o, 0);
            end
        end
        in_valid_i = 1'b0; in_last_i = 1'b0;
    endtask

    initial begin
        int seed_dummy;
        logic [W-1:0] held;
        seed_dummy = $urandom(32'h5EED_0A11);

        #35;
        chk(busy_o === 0 && out_valid_o === 0 && red_done_o === 0 && out_last_o === 0,
            "R1 reset flags", {busy_o, out_valid_o, red_done_o, out_last_o}, 0);
        chk(out_data_o === 0 && red_data_o === 0, "R1 reset data", out_data_o, 0);
        @(negedge clk); rst_n = 1'b1;

        // R2: elements while idle are ignored
        in_valid_i = 1'b1; in_last_i = 1'b1; a_i = 16'h1234; b_i = 16'h0001;
        repeat (3) begin
            @(negedge clk);
            chk(out_valid_o === 0 && red_done_o === 0 && busy_o === 0, "R2 idle elements ignored",
                {out_valid_o, red_done_o, busy_o}, 0);
        end
        in_valid_i = 1'b0;

        // directed corners
        a_arr[0] = 16'h8000; b_arr[0] = 16'h7FFF;
        a_arr[1] = 16'h0005; b_arr[1] = 16'h0005;
        a_arr[2] = 16'hFFFF; b_arr[2] = 16'h0001;
        a_arr[3] = 16'h0003; b_arr[3] = 16'hFFFD;
        run_instr(4'd7, 16'h0, 4, 1'b0, 1'b0);   // R5 test: less, equal, less, greater
        run_instr(4'd6, 16'h0, 4, 1'b0, 1'b0);   // R5 larger with negatives
        run_instr(4'd4, 16'h0, 4, 1'b0, 1'b0);   // R4 multiply low bits
        run_instr(4'd0, 16'h0, 4, 1'b0, 1'b0);   // R4 complement
        run_instr(4'd5, 16'h0, 4, 1'b0, 1'b0);   // R4 and
        run_instr(4'd3, 16'h0, 4, 1'b0, 1'b0);   // R4 add
        run_instr(4'd8, 16'h7FFF, 4, 1'b0, 1'b1);// R6 scalar add with stray scalar
        a_arr[0] = 16'h7FFF; a_arr[1] = 16'h0001; a_arr[2] = 16'h0010;
        run_instr(4'd1, 16'h0, 3, 1'b0, 1'b0);   // R7 wrapping sum
        a_arr[0] = 16'hFFF0; a_arr[1] = 16'hFF00; a_arr[2] = 16'hFFFE;
        run_instr(4'd2, 16'h0, 3, 1'b0, 1'b0);   // R8 all negative max
        a_arr[0] = 16'h8000;
        run_instr(4'd2, 16'h0, 1, 1'b0, 1'b0);   // R8 single element most negative
        run_instr(4'd12, 16'h0, 2, 1'b0, 1'b0);  // R11 unassigned opcode

        // R7 red_data holds after done pulse while idle
        held = red_data_o;
        repeat (2) @(negedge clk);
        chk(red_data_o === held && red_done_o === 0, "R7 result holds", red_data_o, held);

        // random chained instructions with gaps and stray starts
        for (int k = 0; k < 60; k++) begin
            int n;
            n = 1 + ($urandom % 20);
            for (int j = 0; j < n; j++) begin
                a_arr[j] = $urandom; b_arr[j] = $urandom;
            end
            run_instr(4'($urandom % 16), 16'($urandom), n, 1'b1, 1'b1);
        end

        @(negedge clk);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule